// File: doc/BRIEF.md
# Shared 1.5-Bit Quantizer Control for a Double-Sampled Pipeline Stage

This block is the digital side of a 1.5-bit pipeline stage quantizer. Two comparators judge the stage input against an upper threshold (+Vref/4) and a lower threshold (-Vref/4). Their decisions are only meaningful for half a clock period. The block captures each decision at the end of its evaluate half and holds it as a full-period level. From the held pair it derives the stage's 2-bit code.

One quantizer is shared by interleaved sampling paths, so the block keeps one code and one reference-select triplet for each path. A path's triplet is reloaded only when an evaluation that belongs to that path completes. Each triplet is one-hot. It tells the residue amplifier of that path to subtract Vref (X), add Vref (Y) or leave the reference out (Z), so the residue becomes 2*Vin - X*Vref + Y*Vref. The comparators and the switched-capacitor network are analog and stay outside the block.

An evaluation cycle is a cycle in which `cmp_eval` is high. Comparator outputs are active-low, so a low level on `cmp_hi_n` means the input is above +Vref/4, and a low level on `cmp_lo_n` means the input is above -Vref/4. When the upper comparator reports "above" and the lower one reports "below", the pair is contradictory. The block raises an error flag for it and falls back to the mid code.

Top module: `halfbit_quant_ctrl`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge) sets `code` to 01, clears `code_err`, sets every path code to 01, and selects Z only in every triplet.
- R2: At the edge that samples an evaluation cycle, `code` takes the value 10 if both comparators report "above", 01 if only the lower comparator reports "above", and 00 if neither does. With active-low inputs: `cmp_hi_n`=0 and `cmp_lo_n`=0 give 10, `cmp_hi_n`=1 and `cmp_lo_n`=0 give 01, and both at 1 give 00.
- R3: `code` and every path code never take the value 11.
- R4: The contradictory pair (`cmp_hi_n`=0, `cmp_lo_n`=1) sets `code_err` high and `code` to 01, and the owning path receives code 01 with Z selected. `code_err` drops when a consistent pair is next evaluated.
- R5: Outside evaluation cycles the comparator inputs and `cmp_path` are ignored. `code` and `code_err` hold their values until the next evaluation.
- R6: The path that `cmp_path` names during an evaluation cycle loads its code and triplet at the second clock edge after that cycle. Path i occupies bits [2i+1:2i] of `path_code`.
- R7: A path whose index was not named by an evaluation keeps its code and triplet unchanged, including when evaluations for the paths arrive in back-to-back cycles.
- R8: Each triplet is one-hot: `sel_x` for code 10, `sel_y` for code 00, `sel_z` for code 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stage clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmp_eval | input | 1 | High during the evaluate half in which comparator outputs are valid |
| cmp_path | input | PATH_W | Index of the sampling path that owns the current evaluation |
| cmp_hi_n | input | 1 | Upper comparator, low when input is above +Vref/4 |
| cmp_lo_n | input | 1 | Lower comparator, low when input is above -Vref/4 |
| code | output | 2 | Held 2-bit stage code of the latest evaluation |
| code_err | output | 1 | Latest evaluation was a contradictory comparator pair |
| path_code | output | 2*NUM_PATHS | Held code for each path |
| sel_x | output | NUM_PATHS | Per-path select: subtract Vref |
| sel_y | output | NUM_PATHS | Per-path select: add Vref |
| sel_z | output | NUM_PATHS | Per-path select: no reference |

## Verification
The bench sweeps every comparator pair on every path. After each evaluation it drives different values onto the comparator and path inputs. A design that fails to stretch the result, or that still listens outside the evaluate half, would then show a changed code. The contradictory pair is checked for the flag, the mid code and the Z select, since a careless decoder would emit 11 or select X. Back-to-back evaluations for the two paths are used to catch a bank that loads the wrong path, loads one cycle early, or disturbs the other path's held triplet.

// File: rtl/halfbit_quant_pkg.sv
// Shared types and decode helpers for the 1.5-bit quantizer control.
package halfbit_quant_pkg;

    // Stage code values; 2'b11 is not a member and is never produced.
    typedef enum logic [1:0] {
        QCODE_LOW  = 2'b00,
        QCODE_MID  = 2'b01,
        QCODE_HIGH = 2'b10
    } qcode_t;

    // Reference-select triplet for one residue amplifier path.
    typedef struct packed {
        logic x;   // subtract Vref
        logic y;   // add Vref
        logic z;   // no reference
    } qsel_t;

    // Map a stage code onto its one-hot select triplet.
    function automatic qsel_t code_to_sel(input qcode_t c);
        qsel_t s;
        s = '{x: 1'b0, y: 1'b0, z: 1'b0};
        case (c)
            QCODE_HIGH: s.x = 1'b1;
            QCODE_LOW:  s.y = 1'b1;
            default:    s.z = 1'b1;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/halfbit_quant_stretch.sv
// Pulse stretcher for the two comparator decisions.
// Captures the active-high decisions at the end of each evaluate half and
// holds them for a full period until the next evaluation. Also emits a
// one-cycle "fresh" strobe tagged with the owning path index.
// Assumes cmp_eval is high for exactly the cycles in which the comparator
// outputs are valid; other cycles carry the comparator reset state.
module halfbit_quant_stretch #(
    parameter int PATH_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval_i,
    input  logic [PATH_W-1:0] path_i,
    input  logic              above_hi_i,
    input  logic              above_lo_i,
    output logic              hold_hi_o,
    output logic              hold_lo_o,
    output logic              fresh_o,
    output logic [PATH_W-1:0] fresh_path_o
);

    // Hold the decision pair; reset value decodes to the mid code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_hi_o <= 1'b0;
            hold_lo_o <= 1'b1;
        end else if (eval_i) begin
            hold_hi_o <= above_hi_i;
            hold_lo_o <= above_lo_i;
        end
    end

    // Flag a newly captured decision and remember which path owns it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fresh_o      <= 1'b0;
            fresh_path_o <= '0;
        end else begin
            fresh_o <= eval_i;
            if (eval_i) begin
                fresh_path_o <= path_i;
            end
        end
    end

endmodule

// File: rtl/halfbit_quant_decode.sv
// Combinational thermometer-to-code decoder for two comparator levels.
// Assumes active-high "above threshold" inputs. The contradictory pair
// (above the upper threshold yet below the lower) is flagged and mapped
// to the mid code so that the residue path stays in range.
module halfbit_quant_decode
    import halfbit_quant_pkg::*;
(
    input  logic   above_hi_i,
    input  logic   above_lo_i,
    output qcode_t code_o,
    output logic   err_o
);

    // Translate the held decision pair into a legal stage code.
    always_comb begin
        err_o = 1'b0;
        unique case ({above_hi_i, above_lo_i})
            2'b11:   code_o = QCODE_HIGH;
            2'b01:   code_o = QCODE_MID;
            2'b00:   code_o = QCODE_LOW;
            default: begin
                code_o = QCODE_MID;
                err_o  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/halfbit_quant_path_bank.sv
// Per-path held code and reference-select triplet.
// Each path register loads only when a fresh decision tagged with its own
// index arrives; all other paths keep their held state. Assumes at most
// one fresh decision per cycle.
module halfbit_quant_path_bank
    import halfbit_quant_pkg::*;
#(
    parameter int NUM_PATHS = 2,
    parameter int PATH_W    = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fresh_i,
    input  logic [PATH_W-1:0]      fresh_path_i,
    input  qcode_t                 code_i,
    output logic [2*NUM_PATHS-1:0] path_code_o,
    output logic [NUM_PATHS-1:0]   sel_x_o,
    output logic [NUM_PATHS-1:0]   sel_y_o,
    output logic [NUM_PATHS-1:0]   sel_z_o
);

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        qcode_t code_q;
        qsel_t  sel_q;
        logic   load;

        // Decide whether this path owns the fresh decision.
        always_comb load = fresh_i && (fresh_path_i == PATH_W'(p));

        // Hold this path's code and triplet between its own updates.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                code_q <= QCODE_MID;
                sel_q  <= code_to_sel(QCODE_MID);
            end else if (load) begin
                code_q <= code_i;
                sel_q  <= code_to_sel(code_i);
            end
        end

        // Drive this path's slice of the flat outputs.
        always_comb begin
            path_code_o[2*p +: 2] = code_q;
            sel_x_o[p]            = sel_q.x;
            sel_y_o[p]            = sel_q.y;
            sel_z_o[p]            = sel_q.z;
        end
    end

endmodule

// File: rtl/halfbit_quant_ctrl.sv
// Top of the shared 1.5-bit quantizer control.
// Stretches the half-period comparator decisions, decodes the stage code
// and keeps one code plus one-hot reference-select triplet per interleaved
// sampling path. Comparator outputs are active-low (high in their reset half).
module halfbit_quant_ctrl
    import halfbit_quant_pkg::*;
#(
    parameter int NUM_PATHS = 2,
    localparam int PATH_W   = (NUM_PATHS > 1) ? $clog2(NUM_PATHS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmp_eval,
    input  logic [PATH_W-1:0]      cmp_path,
    input  logic                   cmp_hi_n,
    input  logic                   cmp_lo_n,
    output logic [1:0]             code,
    output logic                   code_err,
    output logic [2*NUM_PATHS-1:0] path_code,
    output logic [NUM_PATHS-1:0]   sel_x,
    output logic [NUM_PATHS-1:0]   sel_y,
    output logic [NUM_PATHS-1:0]   sel_z
);

    logic              above_hi;
    logic              above_lo;
    logic              hold_hi;
    logic              hold_lo;
    logic              fresh;
    logic [PATH_W-1:0] fresh_path;
    qcode_t            held_code;

    // Convert the active-low comparator outputs into "above" levels.
    always_comb begin
        above_hi = ~cmp_hi_n;
        above_lo = ~cmp_lo_n;
    end

    halfbit_quant_stretch #(
        .PATH_W (PATH_W)
    ) stretch_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .eval_i       (cmp_eval),
        .path_i       (cmp_path),
        .above_hi_i   (above_hi),
        .above_lo_i   (above_lo),
        .hold_hi_o    (hold_hi),
        .hold_lo_o    (hold_lo),
        .fresh_o      (fresh),
        .fresh_path_o (fresh_path)
    );

    halfbit_quant_decode decode_i (
        .above_hi_i (hold_hi),
        .above_lo_i (hold_lo),
        .code_o     (held_code),
        .err_o      (code_err)
    );

    halfbit_quant_path_bank #(
        .NUM_PATHS (NUM_PATHS),
        .PATH_W    (PATH_W)
    ) bank_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .fresh_i      (fresh),
        .fresh_path_i (fresh_path),
        .code_i       (held_code),
        .path_code_o  (path_code),
        .sel_x_o      (sel_x),
        .sel_y_o      (sel_y),
        .sel_z_o      (sel_z)
    );

    // Expose the shared held code.
    always_comb code = held_code;

endmodule

// File: rtl/halfbit_quant_ctrl_chk.sv
// Property checker for halfbit_quant_ctrl, attached by bind.
module halfbit_quant_ctrl_chk #(
    parameter int NUM_PATHS = 2,
    localparam int PATH_W   = (NUM_PATHS > 1) ? $clog2(NUM_PATHS) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cmp_eval,
    input logic [PATH_W-1:0]      cmp_path,
    input logic [1:0]             code,
    input logic                   code_err,
    input logic [2*NUM_PATHS-1:0] path_code,
    input logic [NUM_PATHS-1:0]   sel_x,
    input logic [NUM_PATHS-1:0]   sel_y,
    input logic [NUM_PATHS-1:0]   sel_z
);

    assert_reset_mid_R1: assert property (@(posedge clk)
        !rst_n |=> (code == 2'b01) && !code_err);

    assert_code_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        code != 2'b11);

    assert_err_mid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        code_err |-> code == 2'b01);

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_eval |=> $stable(code) && $stable(code_err));

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_chk
        assert_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $countones({sel_x[p], sel_y[p], sel_z[p]}) == 1);

        assert_path_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
            path_code[2*p +: 2] != 2'b11);

        assert_other_path_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !(cmp_eval && (cmp_path == PATH_W'(p))) |=> ##1
                ($stable(path_code[2*p +: 2]) && $stable(sel_x[p])
                 && $stable(sel_y[p]) && $stable(sel_z[p])));
    end

endmodule

bind halfbit_quant_ctrl halfbit_quant_ctrl_chk #(
    .NUM_PATHS (NUM_PATHS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_eval  (cmp_eval),
    .cmp_path  (cmp_path),
    .code      (code),
    .code_err  (code_err),
    .path_code (path_code),
    .sel_x     (sel_x),
    .sel_y     (sel_y),
    .sel_z     (sel_z)
);

// File: tb/halfbit_quant_ctrl_tb_top.sv
// Self-checking bench: sweeps every comparator pair on every path.
module halfbit_quant_ctrl_tb_top;

    localparam int NP = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmp_eval = 1'b0;
    logic [0:0]    cmp_path = 1'b0;
    logic          cmp_hi_n = 1'b1;
    logic          cmp_lo_n = 1'b1;
    logic [1:0]    code;
    logic          code_err;
    logic [2*NP-1:0] path_code;
    logic [NP-1:0] sel_x;
    logic [NP-1:0] sel_y;
    logic [NP-1:0] sel_z;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;
    logic [1:0] exp_path [NP];

    halfbit_quant_ctrl #(.NUM_PATHS(NP)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_eval  (cmp_eval),
        .cmp_path  (cmp_path),
        .cmp_hi_n  (cmp_hi_n),
        .cmp_lo_n  (cmp_lo_n),
        .code      (code),
        .code_err  (code_err),
        .path_code (path_code),
        .sel_x     (sel_x),
        .sel_y     (sel_y),
        .sel_z     (sel_z)
    );

    always #4 clk = ~clk;

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected code from active-low comparator levels, per R2 and R4.
    function automatic logic [1:0] exp_code(input logic hn, input logic ln);
        if (!hn && !ln) return 2'b10;
        if (hn && !ln)  return 2'b01;
        if (hn && ln)   return 2'b00;
        return 2'b01;
    endfunction

    // Expected {x,y,z} for a code, per R8.
    function automatic logic [2:0] exp_sel(input logic [1:0] c);
        return (c == 2'b10) ? 3'b100 : (c == 2'b00) ? 3'b010 : 3'b001;
    endfunction

    task automatic check_paths(input string req);
        for (int p = 0; p < NP; p++) begin
            check({req, " path code"}, int'(path_code[2*p +: 2]), int'(exp_path[p]));
            check({req, " triplet"}, int'({sel_x[p], sel_y[p], sel_z[p]}),
                  int'(exp_sel(exp_path[p])));
        end
    endtask

    // One evaluation followed by idle cycles with disturbed inputs.
    task automatic eval_once(input logic hn, input logic ln, input int p);
        logic [1:0] c;
        c = exp_code(hn, ln);
        @(negedge clk);
        cmp_eval = 1'b1; cmp_path = 1'(p); cmp_hi_n = hn; cmp_lo_n = ln;
        @(negedge clk);
        // R2/R6: shared code visible one edge after the evaluation cycle.
        check("R2 code", int'(code), int'(c));
        check("R4 err", int'(code_err), int'(!hn && ln));
        // Path not yet loaded (R6 latency).
        check_paths("R6 before load");
        cmp_eval = 1'b0; cmp_path = 1'(1 - p); cmp_hi_n = ~hn; cmp_lo_n = ~ln;
        exp_path[p] = c;
        @(negedge clk);
        // R6/R7/R8: owning path loaded, other path unchanged.
        check_paths("R7 R8 after load");
        // R5: disturbed inputs outside evaluation are ignored.
        check("R5 held code", int'(code), int'(c));
        cmp_hi_n = 1'b1; cmp_lo_n = 1'b1;
        @(negedge clk);
        check("R5 held err", int'(code_err), int'(!hn && ln));
        check("R3 no 11", int'(code == 2'b11), 0);
    endtask

    initial begin
        for (int p = 0; p < NP; p++) exp_path[p] = 2'b01;
        repeat (3) @(negedge clk);
        // R1: reset state.
        check("R1 code", int'(code), 1);
        check("R1 err", int'(code_err), 0);
        check_paths("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_paths("R1 after release");

        // Full sweep of comparator pairs on each path, two passes.
        for (int pass = 0; pass < 2; pass++)
            for (int p = 0; p < NP; p++)
                for (int v = 0; v < 4; v++)
                    eval_once(v[1], v[0], (pass == 0) ? p : NP - 1 - p);

        // R7: back-to-back evaluations for the two paths.
        @(negedge clk);
        cmp_eval = 1'b1; cmp_path = 1'b0; cmp_hi_n = 1'b0; cmp_lo_n = 1'b0;
        @(negedge clk);
        cmp_path = 1'b1; cmp_hi_n = 1'b1; cmp_lo_n = 1'b1;
        @(negedge clk);
        cmp_eval = 1'b0;
        exp_path[0] = 2'b10;
        check("R7 b2b path0 code", int'(path_code[1:0]), 2);
        @(negedge clk);
        exp_path[1] = 2'b00;
        check_paths("R7 b2b");
        check("R2 b2b code", int'(code), 0);

        // R4: contradictory pair then consistent pair clears the flag.
        eval_once(1'b0, 1'b1, 1);
        check("R4 triplet Z", int'({sel_x[1], sel_y[1], sel_z[1]}), 1);
        eval_once(1'b1, 1'b0, 1);
        check("R4 flag cleared", int'(code_err), 0);

        // R1: reset mid-run restores the reset state.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        for (int p = 0; p < NP; p++) exp_path[p] = 2'b01;
        check("R1 rerun code", int'(code), 1);
        check_paths("R1 rerun");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule